// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Bank

This block holds the digital codes for an eight-channel, 13-bit digital-to-analog converter. Each channel has two stages: a staging register and a live register. A host writes a staging register through a parallel data bus and a channel address. The write is enabled while the chip-select and write strobes are both low. Four active-low load lines each move one fixed pair of staging registers into the matching live registers. Asserting several load lines at once updates those channels together. The live registers drive the converter codes.

The level-sensitive behaviour is modelled with clocked registers, and the control inputs are sampled on every rising clock edge. An open staging register takes the bus value in the same cycle. If the channel's load line is also low in that cycle, the bus value continues on into the live register on the same edge.

An active-low clear sets every register in both stages to the midscale code 0x1000, and it overrides all other controls. A synchronous active-high reset, used as the power-on reset, has the same effect.

An optional signed input mode accepts two's-complement data. In that mode the most significant bit is inverted before the value is stored, which converts it to offset binary.

Top module: `dac_regbank`

## Requirements
- R1: Code output channel k occupies bits [13k+12:13k] of `dac_code`. After reset every channel code reads 0x1000.
- R2: A write stores the bus value into the staging register of the addressed channel. The live register does not change until that channel's load line goes low.
- R3: The staging registers take a value only in a cycle where `cs_n` and `wr_n` are both sampled low. If either strobe is high, the staging registers keep their contents.
- R4: Address values 0 through 7 select channels 0 through 7 in order. A write changes exactly one channel's staging register.
- R5: Load line g (`ld_n[g]` low) copies the staging registers of channels 2g and 2g+1 into their live registers on the next clock edge. All other live registers keep their values.
- R6: With all four load lines low, every live register takes its staging value on the same clock edge.
- R7: When a write and the matching load line are low in the same cycle, the live register takes the bus value after a single clock edge.
- R8: While `clr_n` is low, every staging and live register is set to 0x1000. This happens regardless of `cs_n`, `wr_n`, `ld_n` and the bus.
- R9: `rst` high sets every staging and live register to 0x1000, in the same way as R8.
- R10: With `twos_mode` = 1, the stored value equals the bus value with bit 12 inverted (0x0000→0x1000, 0x1FFF→0x0FFF, 0x0FFF→0x1FFF). With `twos_mode` = 0, the bus value is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Active-low clear to midscale, highest priority |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Channel address for writes |
| data_in | input | 13 | Write data bus |
| twos_mode | input | 1 | 1: bus carries two's-complement data |
| ld_n | input | 4 | Active-low load lines, one per channel pair |
| dac_code | output | 104 | Eight live-register codes, channel k at [13k+12:13k] |

## Verification
Each channel receives a distinct staged value, so a decoding mistake shows up as a value in the wrong channel. The bench then drives load patterns:
- A single pair's load line, to show the effect is confined to that pair.
- All four load lines together, for the simultaneous update.
- A write and a load in the same cycle, for the one-edge path from bus to live register.

Writes are also attempted with only one of the two strobes low; any change from these would expose a single-strobe enable. The clear is applied with every other control active, and reset is applied in the middle of operation. The bench then reloads without writing, which shows that both stages returned to midscale. Three two's-complement codes test the sign-bit conversion: zero, minus one and the most positive value.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

    localparam int unsigned DEF_CHANNELS = 8;
    localparam int unsigned DEF_WIDTH    = 13;
    localparam int unsigned DEF_GROUP    = 2;

    typedef enum logic {
        CODE_OFFSET = 1'b0,
        CODE_TWOS   = 1'b1
    } code_e;

    // per-channel control after sampling and decoding
    typedef struct packed {
        logic clear;
        logic load;
        logic write;
    } chan_ctl_t;

endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic [ADDR_W-1:0]   addr,
    output logic [CHANNELS-1:0] sel
);

    for (genvar k = 0; k < CHANNELS; k++) begin : g_sel
        assign sel[k] = strobe && (addr == ADDR_W'(k));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R4
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> (sel == '0)); // R3

endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_ctl_t        ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] code_q
);

    localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_nxt;

    always_comb begin
        stage_nxt = stage_q;
        if (ctl.write) stage_nxt = din;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            stage_q <= MID;
            code_q  <= MID;
        end else begin
            stage_q <= stage_nxt;
            if (ctl.load) code_q <= stage_nxt;
        end
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.write && !ctl.clear) |=> $stable(stage_q)); // R3
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.clear) |=> $stable(code_q)); // R5
    AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && ctl.write && !ctl.clear) |=> (code_q == $past(din))); // R7
    AST_CLEAR_MID: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (stage_q == MID && code_q == MID)); // R8

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_bank_pkg::*;
#(
    parameter  int unsigned CHANNELS = DEF_CHANNELS,
    parameter  int unsigned WIDTH    = DEF_WIDTH,
    parameter  int unsigned GROUP    = DEF_GROUP,
    localparam int unsigned ADDR_W   = $clog2(CHANNELS),
    localparam int unsigned LOADS    = CHANNELS / GROUP
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_n,
    input  logic                      cs_n,
    input  logic                      wr_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WIDTH-1:0]          data_in,
    input  logic                      twos_mode,
    input  logic [LOADS-1:0]          ld_n,
    output logic [CHANNELS*WIDTH-1:0] dac_code
);

    localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

    code_e            mode;
    logic             strobe;
    logic [WIDTH-1:0] din_conv;
    logic [CHANNELS-1:0] sel;

    assign mode   = code_e'(twos_mode);
    assign strobe = !cs_n && !wr_n;

    always_comb begin
        din_conv = data_in;
        if (mode == CODE_TWOS) din_conv[WIDTH-1] = !data_in[WIDTH-1];
    end

    dac_addr_decode #(
        .CHANNELS (CHANNELS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .addr   (addr),
        .sel    (sel)
    );

    for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
        chan_ctl_t ctl;
        assign ctl.clear = !clr_n;
        assign ctl.load  = !ld_n[k / GROUP];
        assign ctl.write = sel[k];

        dac_chan #(
            .WIDTH (WIDTH)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .din    (din_conv),
            .code_q (dac_code[k*WIDTH +: WIDTH])
        );
    end

    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> (dac_code == {CHANNELS{MID}})); // R9
    AST_TWOS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (strobe && twos_mode && clr_n && !ld_n[addr / ADDR_W'(GROUP)])
        |=> (dac_code[$past(addr)*WIDTH + WIDTH-1] == !$past(data_in[WIDTH-1]))); // R10

endmodule

// File: tb/sim_dac_regbank.sv
`timescale 1ns/1ps
module sim_dac_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [12:0] data_in = '0;
    logic        twos_mode = 1'b0;
    logic [3:0]  ld_n = 4'hF;
    logic [103:0] dac_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_regbank u0 (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .data_in   (data_in),
        .twos_mode (twos_mode),
        .ld_n      (ld_n),
        .dac_code  (dac_code)
    );

    function automatic logic [12:0] ch(input int k);
        return dac_code[k*13 +: 13];
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int k, input logic [12:0] exp);
        checks++;
        if (ch(k) !== exp) begin
            errors++;
            $display("FAIL %s channel %0d actual %h expected %h", req, k, ch(k), exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [12:0] d);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; data_in = d;
        cyc();
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic do_load(input logic [3:0] mask);
        ld_n = mask;
        cyc();
        ld_n = 4'hF;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        for (int k = 0; k < 8; k++) check("R1", k, 13'h1000);
    endtask

    task automatic t_write_then_load_all();
        for (int k = 0; k < 8; k++) do_write(3'(k), 13'h0100 + 13'(k));
        for (int k = 0; k < 8; k++) check("R2", k, 13'h1000);
        do_load(4'h0);
        for (int k = 0; k < 8; k++) check("R4 R6", k, 13'h0100 + 13'(k));
    endtask

    task automatic t_strobe_gate();
        cs_n = 1'b1; wr_n = 1'b0; addr = 3'd2; data_in = 13'h1FFF;
        cyc();
        cs_n = 1'b0; wr_n = 1'b1; data_in = 13'h0AAA;
        cyc();
        cs_n = 1'b1; wr_n = 1'b1;
        do_load(4'h0);
        check("R3", 2, 13'h0102);
    endtask

    task automatic t_pair_load();
        for (int k = 0; k < 8; k++) do_write(3'(k), 13'h0A00 + 13'(k));
        do_load(4'b1101);
        for (int k = 0; k < 8; k++)
            check("R5", k, (k == 2 || k == 3) ? 13'h0A00 + 13'(k) : 13'h0100 + 13'(k));
    endtask

    task automatic t_flow_through();
        cs_n = 1'b0; wr_n = 1'b0; addr = 3'd7; data_in = 13'h1234; ld_n = 4'b0111;
        cyc();
        cs_n = 1'b1; wr_n = 1'b1; ld_n = 4'hF;
        check("R7", 7, 13'h1234);
        check("R5", 6, 13'h0A06);
        check("R5", 5, 13'h0105);
    endtask

    task automatic t_clear();
        clr_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0; addr = 3'd0; data_in = 13'h0555; ld_n = 4'h0;
        cyc();
        for (int k = 0; k < 8; k++) check("R8", k, 13'h1000);
        clr_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1; ld_n = 4'hF;
        do_load(4'h0);
        for (int k = 0; k < 8; k++) check("R8", k, 13'h1000);
    endtask

    task automatic t_reset_midrun();
        for (int k = 0; k < 8; k++) do_write(3'(k), 13'h0777);
        do_load(4'h0);
        check("R9", 4, 13'h0777);
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        for (int k = 0; k < 8; k++) check("R9", k, 13'h1000);
        do_load(4'h0);
        for (int k = 0; k < 8; k++) check("R9", k, 13'h1000);
    endtask

    task automatic t_twos();
        twos_mode = 1'b1;
        do_write(3'd5, 13'h0000);
        do_write(3'd4, 13'h1FFF);
        do_write(3'd1, 13'h0FFF);
        twos_mode = 1'b0;
        do_write(3'd0, 13'h0FFF);
        do_load(4'h0);
        check("R10", 5, 13'h1000);
        check("R10", 4, 13'h0FFF);
        check("R10", 1, 13'h1FFF);
        check("R10", 0, 13'h0FFF);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_then_load_all();
        t_strobe_gate();
        t_pair_load();
        t_flow_through();
        t_clear();
        t_reset_midrun();
        t_twos();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule